// File: doc/BRIEF.md
# Transactional Cache Controller

This block is a small fully associative cache placed next to a processor to hold the working set of a hardware transaction. Each entry stores an address, a data word, a coherence state (invalid, shared, exclusive or modified) and a transactional tag. The tag is one of four values: free, clean (an ordinary resident line), old (the value from before the transaction) or speculative (the value the transaction is building).

Every line that a transaction touches is held twice. The old copy keeps the pre-transaction value. The speculative copy takes every store. Ending the transaction retags all pairs in one clock. A commit keeps the speculative copies and drops the old ones. An abort does the opposite. Transactional loads, exclusive loads and stores that miss fetch the line over a simple request/acknowledge bus port. That port can answer with a busy reply, which makes the access fail.

The block also keeps two flags. The active flag says a transaction is open. The status flag says that transaction is still healthy. A snooped write to any line held in a transactional pair clears the status flag, so software learns that the transaction must abort.

Top module: `txcache_top`

## Requirements
- R1: After reset every entry is free, `tx_active` is 0, `tx_status` is 1, `req_ready` is 1, and `resp_valid` and `bus_req` are 0.
- R2: A load (op 0), exclusive load (op 1) or store (op 2) whose address matches a speculative entry uses that entry. No bus cycle starts and no other entry changes. A load returns the entry's data on `resp_data`. A store writes `req_wdata` into that entry and returns it. The response has `resp_ok`=1 and appears one cycle after acceptance.
- R3: If no speculative entry matches but a clean entry does, the clean entry becomes speculative and one more entry is allocated as its old copy with the same address and data. No bus cycle starts. The response appears one cycle after acceptance.
- R4: If no entry matches, `bus_req` rises with `bus_addr` set to the request address. `bus_excl` is 0 for a load and 1 for an exclusive load or a store. Address and kind hold until `bus_ack`. On a non-busy acknowledge, a speculative entry and an old entry are both created from `bus_rdata`, and a response with `resp_ok`=1 follows one cycle later.
- R5: A store changes only the speculative copy. The old copy keeps the value from before the transaction.
- R6: Commit (op 3) frees every old entry and turns every speculative entry clean in one cycle. It sets `tx_status`=1 and `tx_active`=0 and responds with `resp_ok`=1.
- R7: Abort (op 4) frees every speculative entry and turns every old entry clean in one cycle. It sets `tx_status`=1 and `tx_active`=0 and responds with `resp_ok`=1.
- R8: Validate (op 5) returns the current status on `resp_ok`. When that status is 0, validate also sets `tx_status`=1 and `tx_active`=0.
- R9: An acknowledge with `bus_busy`=1 fails the pending access. The response has `resp_ok`=0, `tx_status` becomes 0 and no entry is created.
- R10: If an access needs more entries than it can get (two for a miss, one for a clean hit), it fails at once with `resp_ok`=0. No bus cycle starts and `tx_status` becomes 0.
- R11: A snoop write (`snoop_wr`=1) whose address matches an old or speculative entry clears `tx_status`. A snoop to any other address leaves it unchanged. A conflicting snoop wins over a status update from an operation in the same cycle.
- R12: Every accepted load, exclusive load or store sets `tx_active` to 1.
- R13: Allocation takes free entries first, lowest index first. It then takes clean entries, scanning from a rotating pointer. The pointer advances by one, modulo the entry count, after each allocation that evicts a clean entry.
- R14: Only one request is handled at a time. `req_ready` is 0 while a bus cycle is pending, and each accepted request gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 3 | Operation code (0 load, 1 exclusive load, 2 store, 3 commit, 4 abort, 5 validate) |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | Access succeeded, or validate result |
| resp_data | output | DW | Value of the speculative copy after the access |
| bus_req | output | 1 | Bus cycle pending |
| bus_excl | output | 1 | 0 shared fetch, 1 fetch for ownership |
| bus_addr | output | AW | Bus cycle address |
| bus_ack | input | 1 | Bus reply strobe |
| bus_busy | input | 1 | Reply is a busy refusal |
| bus_rdata | input | DW | Fetched line data |
| snoop_wr | input | 1 | Remote write observed |
| snoop_addr | input | AW | Address of the remote write |
| tx_active | output | 1 | Transaction open flag |
| tx_status | output | 1 | Transaction healthy flag |

## Verification
The bound checker watches several rules on every cycle. It confirms that speculative and old entries always come in equal numbers. It confirms that commit and abort leave no transactional entry and restore both flags. It also checks that validate clears a failed status, that a busy reply fails the access, that every access raises the active flag, and that a pending bus cycle holds its address and kind. Only the bench's scenarios can show the rest: which entry replacement picks as the rotating pointer moves, that an evicted line misses later, that stores leave the old copy untouched across an abort, and that snoops to unrelated addresses do nothing.

// File: rtl/txc_pkg.sv
`timescale 1ns/1ps
package txc_pkg;

    typedef enum logic [1:0] {
        TAG_FREE  = 2'd0,
        TAG_CLEAN = 2'd1,
        TAG_OLD   = 2'd2,
        TAG_SPEC  = 2'd3
    } tag_e;

    typedef enum logic [1:0] {
        MS_I = 2'd0,
        MS_S = 2'd1,
        MS_E = 2'd2,
        MS_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        OP_LD       = 3'd0,
        OP_LDX      = 3'd1,
        OP_ST       = 3'd2,
        OP_COMMIT   = 3'd3,
        OP_ABORT    = 3'd4,
        OP_VALIDATE = 3'd5
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } fsm_e;

    function automatic logic is_access(op_e op);
        return (op == OP_LD) || (op == OP_LDX) || (op == OP_ST);
    endfunction

    // state a freshly filled line takes, by requesting operation
    function automatic mesi_e fill_state(op_e op);
        return (op == OP_LD) ? MS_S : MS_E;
    endfunction

endpackage

// File: rtl/txc_match.sv
`timescale 1ns/1ps
module txc_match
    import txc_pkg::*;
#(
    parameter  int ENTRIES = 4,
    parameter  int AW      = 16,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  tag_e [ENTRIES-1:0]          tags,
    input  logic [ENTRIES-1:0][AW-1:0]  addrs,
    input  logic [AW-1:0]               key,
    output logic                        spec_hit,
    output logic [IW-1:0]               spec_idx,
    output logic                        clean_hit,
    output logic [IW-1:0]               clean_idx
);
    always_comb begin
        spec_hit  = 1'b0;
        spec_idx  = '0;
        clean_hit = 1'b0;
        clean_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (addrs[i] == key) begin
                if (tags[i] == TAG_SPEC && !spec_hit) begin
                    spec_hit = 1'b1;
                    spec_idx = IW'(i);
                end
                if (tags[i] == TAG_CLEAN && !clean_hit) begin
                    clean_hit = 1'b1;
                    clean_idx = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/txc_victim.sv
`timescale 1ns/1ps
module txc_victim
    import txc_pkg::*;
#(
    parameter  int ENTRIES = 4,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  tag_e [ENTRIES-1:0] tags,
    input  logic [ENTRIES-1:0] excl,
    input  logic [IW-1:0]      ptr,
    output logic               found0,
    output logic [IW-1:0]      slot0,
    output logic               evict0,
    output logic               found1,
    output logic [IW-1:0]      slot1,
    output logic               evict1
);
    logic [IW:0]   sum;
    logic [IW-1:0] j;

    always_comb begin
        found0 = 1'b0; slot0 = '0; evict0 = 1'b0;
        found1 = 1'b0; slot1 = '0; evict1 = 1'b0;
        sum = '0;
        j   = '0;
        // pass one: free entries, lowest index first
        for (int i = 0; i < ENTRIES; i++) begin
            if (tags[i] == TAG_FREE && !excl[i]) begin
                if (!found0) begin
                    found0 = 1'b1; slot0 = IW'(i);
                end else if (!found1) begin
                    found1 = 1'b1; slot1 = IW'(i);
                end
            end
        end
        // pass two: clean entries, starting at the rotating pointer
        for (int k = 0; k < ENTRIES; k++) begin
            sum = {1'b0, ptr} + (IW+1)'(k);
            if (sum >= (IW+1)'(ENTRIES)) sum = sum - (IW+1)'(ENTRIES);
            j = sum[IW-1:0];
            if (tags[j] == TAG_CLEAN && !excl[j]) begin
                if (!found0) begin
                    found0 = 1'b1; slot0 = j; evict0 = 1'b1;
                end else if (!found1) begin
                    found1 = 1'b1; slot1 = j; evict1 = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/txcache_top.sv
`timescale 1ns/1ps
module txcache_top
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 16,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_valid,
    output logic          resp_ok,
    output logic [DW-1:0] resp_data,
    output logic          bus_req,
    output logic          bus_excl,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_ack,
    input  logic          bus_busy,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snoop_wr,
    input  logic [AW-1:0] snoop_addr,
    output logic          tx_active,
    output logic          tx_status
);
    localparam int IW = $clog2(ENTRIES);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } pend_t;

    tag_e  [ENTRIES-1:0]         tag_q;
    mesi_e [ENTRIES-1:0]         mesi_q;
    logic  [ENTRIES-1:0][AW-1:0] addr_q;
    logic  [ENTRIES-1:0][DW-1:0] data_q;
    logic  [IW-1:0]              ptr_q;
    fsm_e                        state_q;
    pend_t                       pend_q;

    op_e           op_in;
    logic [AW-1:0] key;
    logic          spec_hit, clean_hit;
    logic [IW-1:0] spec_idx, clean_idx;
    logic [ENTRIES-1:0] excl;
    logic          found0, found1, evict0, evict1;
    logic [IW-1:0] slot0, slot1;
    logic [ENTRIES-1:0] spec_mask, old_mask;
    logic          snoop_hit;
    logic [IW-1:0] ptr_next;

    assign op_in     = op_e'(req_op);
    assign key       = (state_q == ST_BUS) ? pend_q.addr : req_addr;
    assign req_ready = (state_q == ST_IDLE);
    assign bus_req   = (state_q == ST_BUS);
    assign bus_excl  = (pend_q.op != OP_LD);
    assign bus_addr  = pend_q.addr;
    assign ptr_next  = (ptr_q == IW'(ENTRIES-1)) ? '0 : ptr_q + IW'(1);

    txc_match #(.ENTRIES(ENTRIES), .AW(AW)) u_match (
        .tags(tag_q), .addrs(addr_q), .key(key),
        .spec_hit(spec_hit), .spec_idx(spec_idx),
        .clean_hit(clean_hit), .clean_idx(clean_idx)
    );

    // the clean line being promoted may not also serve as its own old copy
    always_comb begin
        excl = '0;
        if (state_q == ST_IDLE && clean_hit) excl[clean_idx] = 1'b1;
    end

    txc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .tags(tag_q), .excl(excl), .ptr(ptr_q),
        .found0(found0), .slot0(slot0), .evict0(evict0),
        .found1(found1), .slot1(slot1), .evict1(evict1)
    );

    always_comb begin
        snoop_hit = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            spec_mask[i] = (tag_q[i] == TAG_SPEC);
            old_mask[i]  = (tag_q[i] == TAG_OLD);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (snoop_wr && (spec_mask[i] || old_mask[i]) && addr_q[i] == snoop_addr)
                snoop_hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= TAG_FREE;
                mesi_q[i] <= MS_I;
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
            ptr_q      <= '0;
            state_q    <= ST_IDLE;
            pend_q     <= '0;
            tx_active  <= 1'b0;
            tx_status  <= 1'b1;
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    pend_q     <= '{op: op_in, addr: req_addr, wdata: req_wdata};
                    resp_valid <= 1'b1;
                    resp_ok    <= 1'b0;
                    resp_data  <= '0;
                    if (is_access(op_in)) tx_active <= 1'b1;
                    unique case (op_in)
                        OP_LD, OP_LDX, OP_ST: begin
                            if (spec_hit) begin
                                resp_ok   <= 1'b1;
                                resp_data <= data_q[spec_idx];
                                if (op_in == OP_ST) begin
                                    data_q[spec_idx] <= req_wdata;
                                    mesi_q[spec_idx] <= MS_M;
                                    resp_data        <= req_wdata;
                                end
                            end else if (clean_hit) begin
                                if (found0) begin
                                    tag_q[clean_idx]  <= TAG_SPEC;
                                    tag_q[slot0]      <= TAG_OLD;
                                    addr_q[slot0]     <= req_addr;
                                    data_q[slot0]     <= data_q[clean_idx];
                                    mesi_q[slot0]     <= mesi_q[clean_idx];
                                    resp_ok           <= 1'b1;
                                    resp_data         <= data_q[clean_idx];
                                    if (op_in == OP_ST) begin
                                        data_q[clean_idx] <= req_wdata;
                                        mesi_q[clean_idx] <= MS_M;
                                        resp_data         <= req_wdata;
                                    end
                                    if (evict0) ptr_q <= ptr_next;
                                end else begin
                                    tx_status <= 1'b0;
                                end
                            end else if (found0 && found1) begin
                                state_q    <= ST_BUS;
                                resp_valid <= 1'b0;
                            end else begin
                                tx_status <= 1'b0;
                            end
                        end
                        OP_COMMIT, OP_ABORT: begin
                            for (int i = 0; i < ENTRIES; i++) begin
                                if (tag_q[i] == ((op_in == OP_COMMIT) ? TAG_OLD : TAG_SPEC))
                                    tag_q[i] <= TAG_FREE;
                                else if (tag_q[i] == ((op_in == OP_COMMIT) ? TAG_SPEC : TAG_OLD))
                                    tag_q[i] <= TAG_CLEAN;
                            end
                            tx_status <= 1'b1;
                            tx_active <= 1'b0;
                            resp_ok   <= 1'b1;
                        end
                        OP_VALIDATE: begin
                            resp_ok <= tx_status;
                            if (!tx_status) begin
                                tx_status <= 1'b1;
                                tx_active <= 1'b0;
                            end
                        end
                        default: resp_ok <= 1'b0;
                    endcase
                end
                ST_BUS: if (bus_ack) begin
                    state_q    <= ST_IDLE;
                    resp_valid <= 1'b1;
                    resp_ok    <= !bus_busy;
                    resp_data  <= '0;
                    if (bus_busy) begin
                        tx_status <= 1'b0;
                    end else begin
                        tag_q[slot0]  <= TAG_SPEC;
                        addr_q[slot0] <= pend_q.addr;
                        data_q[slot0] <= (pend_q.op == OP_ST) ? pend_q.wdata : bus_rdata;
                        mesi_q[slot0] <= (pend_q.op == OP_ST) ? MS_M : fill_state(pend_q.op);
                        tag_q[slot1]  <= TAG_OLD;
                        addr_q[slot1] <= pend_q.addr;
                        data_q[slot1] <= bus_rdata;
                        mesi_q[slot1] <= fill_state(pend_q.op);
                        resp_data     <= (pend_q.op == OP_ST) ? pend_q.wdata : bus_rdata;
                        if (evict0 || evict1) ptr_q <= ptr_next;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (snoop_hit) tx_status <= 1'b0;
        end
    end
endmodule

// File: rtl/txc_checker.sv
`timescale 1ns/1ps
module txc_checker
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [2:0]         req_op,
    input logic               resp_valid,
    input logic               resp_ok,
    input logic               bus_req,
    input logic               bus_excl,
    input logic [AW-1:0]      bus_addr,
    input logic               bus_ack,
    input logic               bus_busy,
    input logic               snoop_wr,
    input logic               tx_active,
    input logic               tx_status,
    input logic [ENTRIES-1:0] spec_mask,
    input logic [ENTRIES-1:0] old_mask
);
    logic take;
    assign take = req_valid && req_ready;

    assert_reset_flags_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tx_status && !tx_active && !resp_valid && req_ready));

    assert_pairs_balanced_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(spec_mask) == $countones(old_mask));

    assert_bus_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_excl)));

    assert_commit_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_COMMIT && !snoop_wr) |=>
        (tx_status && !tx_active && resp_valid && resp_ok && spec_mask == '0 && old_mask == '0));

    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_ABORT && !snoop_wr) |=>
        (tx_status && !tx_active && resp_valid && resp_ok && spec_mask == '0 && old_mask == '0));

    assert_validate_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == OP_VALIDATE && !tx_status && !snoop_wr) |=>
        (tx_status && !tx_active && resp_valid && !resp_ok));

    assert_busy_fails_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_busy) |=> (!tx_status && resp_valid && !resp_ok));

    assert_access_activates_R12: assert property (@(posedge clk) disable iff (rst)
        (take && (req_op == OP_LD || req_op == OP_LDX || req_op == OP_ST)) |=> tx_active);

endmodule

bind txcache_top txc_checker #(.ENTRIES(ENTRIES), .AW(AW)) u_txc_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .resp_valid(resp_valid), .resp_ok(resp_ok),
    .bus_req(bus_req), .bus_excl(bus_excl), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_busy(bus_busy), .snoop_wr(snoop_wr),
    .tx_active(tx_active), .tx_status(tx_status),
    .spec_mask(spec_mask), .old_mask(old_mask)
);

// File: tb/test_txcache_top.sv
`timescale 1ns/1ps
module test_txcache_top;
    localparam int E = 4;
    // operation codes and tag codes used by the model
    localparam int LD = 0, LDX = 1, ST = 2, CMT = 3, ABT = 4, VAL = 5;
    localparam int FREE = 0, CLEAN = 1, OLD = 2, SPEC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, resp_ok;
    logic [31:0] resp_data;
    logic        bus_req, bus_excl;
    logic [15:0] bus_addr;
    logic        bus_ack = 1'b0, bus_busy = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        snoop_wr = 1'b0;
    logic [15:0] snoop_addr = '0;
    logic        tx_active, tx_status;

    txcache_top #(.ENTRIES(E), .AW(16), .DW(32)) i_txcache_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_data(resp_data),
        .bus_req(bus_req), .bus_excl(bus_excl), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_busy(bus_busy), .bus_rdata(bus_rdata),
        .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
        .tx_active(tx_active), .tx_status(tx_status)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errs   = 0;
    bit cmp_on = 0;

    // behavioural model state
    int mt[E];
    int ma[E];
    int md[E];
    int mptr = 0;
    bit mact = 0;
    bit mst  = 1;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errs);
    endtask

    function automatic int find(input int tg, input int a);
        for (int i = 0; i < E; i++) if (mt[i] == tg && ma[i] == a) return i;
        return -1;
    endfunction

    // candidate list: free entries ascending, then clean entries from the pointer
    task automatic pick(input int skip, output int cnt, output int v0, output int v1,
                        output bit c0, output bit c1);
        int q[$];
        bit cl[$];
        for (int i = 0; i < E; i++)
            if (mt[i] == FREE && i != skip) begin q.push_back(i); cl.push_back(1'b0); end
        for (int k = 0; k < E; k++) begin
            int j = (mptr + k) % E;
            if (mt[j] == CLEAN && j != skip) begin q.push_back(j); cl.push_back(1'b1); end
        end
        cnt = q.size();
        v0 = (cnt > 0) ? q[0] : 0;  c0 = (cnt > 0) ? cl[0] : 1'b0;
        v1 = (cnt > 1) ? q[1] : 0;  c1 = (cnt > 1) ? cl[1] : 1'b0;
    endtask

    // flags compared with the model on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(tx_active == mact, "R12 active flag", tx_active, mact);
            chk(tx_status == mst, "R11 status flag", tx_status, mst);
        end
    end

    task automatic access(input int op, input int a, input int wd, input bit busy,
                          input int rd, input int hold, input string rq);
        int si, ci, cnt, v0, v1, ed;
        bit c0, c1, miss, eok;
        string tagp;
        si = find(SPEC, a);
        ci = find(CLEAN, a);
        miss = 0; eok = 0; ed = 0; cnt = 0; v0 = 0; v1 = 0; c0 = 0; c1 = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = 16'(a); req_wdata = 32'(wd);
        @(posedge clk); #1;
        mact = 1;
        if (si >= 0) begin
            if (op == ST) md[si] = wd;
            eok = 1; ed = md[si]; tagp = "R2";
        end else if (ci >= 0) begin
            pick(ci, cnt, v0, v1, c0, c1);
            tagp = "R3";
            if (cnt >= 1) begin
                mt[v0] = OLD; ma[v0] = a; md[v0] = md[ci];
                mt[ci] = SPEC;
                if (op == ST) md[ci] = wd;
                if (c0) mptr = (mptr + 1) % E;
                eok = 1; ed = md[ci];
            end else begin
                mst = 0; tagp = "R10";
            end
        end else begin
            pick(-1, cnt, v0, v1, c0, c1);
            if (cnt >= 2) begin miss = 1; tagp = "R4"; end
            else begin mst = 0; tagp = "R10"; end
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!miss) begin
            chk(resp_valid == 1'b1, {rq, " ", tagp, " resp_valid"}, resp_valid, 1);
            chk(resp_ok == eok, {rq, " ", tagp, " resp_ok"}, resp_ok, eok);
            if (eok) chk(resp_data == 32'(ed), {rq, " ", tagp, " resp_data"}, resp_data, ed);
            chk(bus_req == 1'b0, {rq, " ", tagp, " no bus cycle"}, bus_req, 0);
        end else begin
            chk(bus_req == 1'b1, {rq, " R4 bus_req"}, bus_req, 1);
            chk(bus_excl == (op != LD), {rq, " R4 bus_excl"}, bus_excl, (op != LD));
            chk(bus_addr == 16'(a), {rq, " R4 bus_addr"}, bus_addr, a);
            chk(req_ready == 1'b0, {rq, " R14 ready low"}, req_ready, 0);
            chk(resp_valid == 1'b0, {rq, " R14 no early resp"}, resp_valid, 0);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                chk(bus_req == 1'b1 && bus_addr == 16'(a), {rq, " R4 hold"}, bus_req, 1);
            end
            bus_ack = 1'b1; bus_busy = busy; bus_rdata = 32'(rd);
            @(posedge clk); #1;
            if (busy) begin
                mst = 0;
            end else begin
                mt[v0] = SPEC; ma[v0] = a; md[v0] = (op == ST) ? wd : rd;
                mt[v1] = OLD;  ma[v1] = a; md[v1] = rd;
                if (c0 || c1) mptr = (mptr + 1) % E;
                eok = 1; ed = md[v0];
            end
            @(negedge clk);
            bus_ack = 1'b0; bus_busy = 1'b0;
            chk(resp_valid == 1'b1, {rq, " R14 resp after ack"}, resp_valid, 1);
            chk(resp_ok == eok, {rq, busy ? " R9 busy fails" : " R4 fill ok"}, resp_ok, eok);
            if (eok) chk(resp_data == 32'(ed), {rq, " R4 fill data"}, resp_data, ed);
            chk(bus_req == 1'b0 && req_ready == 1'b1, {rq, " R14 idle again"}, bus_req, 0);
        end
    endtask

    task automatic control(input int op, input string rq);
        bit prev;
        prev = mst;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op);
        @(posedge clk); #1;
        if (op == CMT || op == ABT) begin
            for (int i = 0; i < E; i++) begin
                if (mt[i] == ((op == CMT) ? OLD : SPEC)) mt[i] = FREE;
                else if (mt[i] == ((op == CMT) ? SPEC : OLD)) mt[i] = CLEAN;
            end
            mst = 1; mact = 0;
        end else if (!mst) begin
            mst = 1; mact = 0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, {rq, " resp_valid"}, resp_valid, 1);
        if (op == VAL) chk(resp_ok == prev, {rq, " R8 validate result"}, resp_ok, prev);
        else chk(resp_ok == 1'b1, {rq, " resp_ok"}, resp_ok, 1);
    endtask

    task automatic snoop(input int a, input string rq);
        @(negedge clk);
        snoop_wr = 1'b1; snoop_addr = 16'(a);
        @(posedge clk); #1;
        for (int i = 0; i < E; i++)
            if ((mt[i] == OLD || mt[i] == SPEC) && ma[i] == a) mst = 0;
        @(negedge clk);
        snoop_wr = 1'b0;
        chk(tx_status == mst, {rq, " R11 snoop"}, tx_status, mst);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errs++;
        $display("FAIL R14 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < E; i++) begin mt[i] = FREE; ma[i] = 0; md[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(resp_valid == 1'b0 && bus_req == 1'b0, "R1 quiet", resp_valid, 0);
        chk(tx_status == 1'b1 && tx_active == 1'b0, "R1 flags", {tx_status, tx_active}, 2);
        cmp_on = 1;

        access(LD, 'h10, 0, 0, 'hAAAA, 2, "miss load");
        access(LD, 'h10, 0, 0, 0, 0, "R2 spec hit load");
        access(ST, 'h10, 'h5555, 0, 0, 0, "R2 R5 spec hit store");
        control(ABT, "R7 abort");
        access(LD, 'h10, 0, 0, 0, 0, "R3 R5 clean hit after abort");
        control(CMT, "R6 commit");
        access(LDX, 'h20, 0, 0, 'h1234, 1, "R4 exclusive miss");
        access(ST, 'h30, 'h7777, 0, 'h3030, 0, "R13 R5 store miss evicts clean");
        snoop('h99, "R11 unrelated");
        snoop('h20, "R11 conflicting");
        control(VAL, "R8 failed validate");
        control(VAL, "R8 healthy validate");
        control(CMT, "R6 commit two");
        access(LD, 'h40, 0, 0, 'h4040, 0, "R12 fill");
        access(LD, 'h50, 0, 0, 'h5050, 0, "R13 rotating eviction");
        access(LD, 'h60, 0, 0, 0, 0, "R10 no room");
        control(ABT, "R7 abort two");
        access(LD, 'h70, 0, 1, 'hDEAD, 1, "R9 busy reply");
        control(VAL, "R8 after busy");
        access(LD, 'h30, 0, 0, 'h3333, 0, "R13 evicted line misses");
        access(LD, 'h20, 0, 0, 'h2222, 0, "R13 pointer picks");
        access(LD, 'h40, 0, 0, 0, 0, "R10 R13 full after rotation");
        control(CMT, "R6 final commit");
        @(negedge clk);
        cmp_on = 0;
        summary();
        $finish;
    end
endmodule